// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a synchronous DRAM burst. A controller pulses `start` with a 9-bit starting column, a burst-length code and a burst-type bit. The first column is registered on that same clock edge, and one further column follows on each later edge. Every emitted column is flagged by `col_valid`. The final beat of a fixed-length burst is also flagged by `col_last`.

There are two beat orderings. In sequential order the low column bits count upward and wrap inside the block aligned to the burst length. In interleaved order each beat's low bits are the starting low bits XORed with the beat number. The column bits above the burst field keep their starting value for the whole burst. A continuous burst is available in sequential order only. It steps through the whole 512-column row without end until `stop` or a new `start` ends it.

A `start` arrives in any cycle, including mid-burst and on the final beat, so bursts can follow each other with no idle cycles. Bank and row handling, refresh and the data path belong to other blocks.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high and on the first edge after it, `col_valid`, `col_last` and `cfg_err` are 0 and `col_out` is 0.
- R2: A `len_sel` code of 0, 1, 2 or 3 selects a burst of 1, 2, 4 or 8 beats. Exactly that many cycles carry `col_valid`, and `col_last` is 1 only on the final one, so a 1-beat burst has `col_last` on its only beat.
- R3: When `intlv` is 0, beat i of a fixed burst of length L carries low bits equal to (start low bits + i) mod L. For example, L=4 starting at 1 gives 1,2,3,0.
- R4: When `intlv` is 1, beat i of a fixed burst carries low bits equal to the start low bits XOR i. For example, L=8 starting at 5 gives 5,4,7,6,1,0,3,2.
- R5: In a fixed burst, column bits above the log2(L) low bits equal those of the starting column on every beat.
- R6: `len_sel` code 4 with `intlv` 0 starts a continuous burst. The column rises by one per cycle and wraps from 511 to 0, and `col_last` is never 1.
- R7: When `stop` is high at a clock edge and `start` is low, `col_valid` is 0 from that edge on. When both are high, the start is taken.
- R8: A start with code 4 and `intlv` 1, or with a code of 5 to 7, raises `cfg_err` for one cycle. It issues no column, and any burst in progress ends.
- R9: A start during a burst abandons the old burst and begins the new one on the next beat. A start on the final beat continues with no idle cycle.
- R10: The first beat, equal to `start_col`, appears on the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new burst this cycle |
| start_col | input | 9 | Starting column address |
| len_sel | input | 3 | Burst length code: 0..3 = 1/2/4/8 beats, 4 = continuous |
| intlv | input | 1 | 0 = sequential order, 1 = interleaved order |
| stop | input | 1 | End the running burst |
| col_out | output | 9 | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a beat |
| col_last | output | 1 | Current beat is the final one of a fixed burst |
| cfg_err | output | 1 | One-cycle pulse for a rejected length/type combination |

## Verification
Three events can land in the same cycle: a new start together with the final beat of the previous burst, a start together with a stop, and a start in the middle of a running burst. The bench provokes each one by raising `start` on the negative edge before the beat in question. For a start on the final beat, the following beat must be the new burst's first column with no gap. For a start together with a stop, the new burst must be taken. For a start mid-burst, the old sequence must be dropped at once. Each expected column is computed from the requirement formulas.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int COL_W     = 9;                 // column address width
    localparam int LEN_W     = 3;                 // length code width
    localparam int MAX_LOG   = 3;                 // longest fixed burst = 2**MAX_LOG
    localparam int NUM_FIXED = MAX_LOG + 1;       // codes 0..MAX_LOG are fixed lengths
    localparam logic [LEN_W-1:0] LEN_CONT = LEN_W'(NUM_FIXED);

    typedef logic [COL_W-1:0] col_t;

    typedef struct packed {
        col_t base;      // starting column
        col_t mask;      // low bits that move within the burst
        logic cont;      // continuous (no end)
        logic intlv;     // XOR ordering
    } burst_cfg_t;

    typedef struct packed {
        col_t col;
        logic last;
    } beat_t;

    function automatic col_t beat_col(input burst_cfg_t cfg, input col_t idx);
        col_t moving;
        moving = cfg.intlv ? (cfg.base ^ idx) : (cfg.base + idx);
        return (cfg.base & ~cfg.mask) | (moving & cfg.mask);
    endfunction

endpackage

// File: rtl/burst_cfg_dec.sv
module burst_cfg_dec
    import burst_seq_pkg::*;
(
    input  col_t              start_col,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              intlv,
    output burst_cfg_t        cfg,
    output logic              bad
);

    always_comb begin
        cfg.base  = start_col;
        cfg.intlv = intlv;
        cfg.cont  = 1'b0;
        cfg.mask  = '0;
        bad       = 1'b0;
        if (int'(len_sel) < NUM_FIXED) begin
            cfg.mask = ~({COL_W{1'b1}} << len_sel);
        end else if (len_sel == LEN_CONT) begin
            cfg.cont = 1'b1;
            cfg.mask = '1;
            bad      = intlv;
        end else begin
            bad = 1'b1;
        end
    end

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
    import burst_seq_pkg::*;
(
    input  burst_cfg_t cfg,
    input  col_t       idx,
    output beat_t      beat
);

    always_comb begin
        beat.col  = beat_col(cfg, idx);
        beat.last = !cfg.cont && (idx == cfg.mask);
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              intlv,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic              cfg_err
);

    burst_cfg_t new_cfg, cur_cfg, sel_cfg;
    logic       new_bad;
    col_t       cnt, sel_idx;
    logic       active;
    beat_t      nxt;

    burst_cfg_dec u_dec (
        .start_col (start_col),
        .len_sel   (len_sel),
        .intlv     (intlv),
        .cfg       (new_cfg),
        .bad       (new_bad)
    );

    always_comb begin
        sel_cfg = start ? new_cfg : cur_cfg;
        sel_idx = start ? '0 : cnt;
    end

    burst_beat_gen u_gen (
        .cfg  (sel_cfg),
        .idx  (sel_idx),
        .beat (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cfg   <= '0;
            cnt       <= '0;
            active    <= 1'b0;
            col_out   <= '0;
            col_valid <= 1'b0;
            col_last  <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            cfg_err <= start && new_bad;
            if (start && new_bad) begin
                active    <= 1'b0;
                col_valid <= 1'b0;
                col_last  <= 1'b0;
            end else if (start) begin
                cur_cfg   <= new_cfg;
                cnt       <= col_t'(1);
                col_out   <= nxt.col;
                col_valid <= 1'b1;
                col_last  <= nxt.last;
                active    <= !nxt.last;
            end else if (stop || !active) begin
                active    <= 1'b0;
                col_valid <= 1'b0;
                col_last  <= 1'b0;
            end else begin
                cnt       <= cnt + col_t'(1);
                col_out   <= nxt.col;
                col_valid <= 1'b1;
                col_last  <= nxt.last;
                active    <= !nxt.last;
            end
        end
    end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
    import burst_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [COL_W-1:0]  start_col,
    input logic [LEN_W-1:0]  len_sel,
    input logic              intlv,
    input logic              stop,
    input logic [COL_W-1:0]  col_out,
    input logic              col_valid,
    input logic              col_last,
    input logic              cfg_err
);

    logic good_start;
    logic cont_live;

    assign good_start = start && (int'(len_sel) < NUM_FIXED || (len_sel == LEN_CONT && !intlv));

    always_ff @(posedge clk) begin
        if (rst)         cont_live <= 1'b0;
        else if (start)  cont_live <= good_start && (len_sel == LEN_CONT);
    end

    assert_last_has_valid_R2: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    assert_err_silent_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !col_valid);

    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !col_valid);

    assert_first_beat_R10: assert property (@(posedge clk) disable iff (rst)
        good_start |=> (col_valid && col_out == $past(start_col)));

    assert_high_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && !cont_live && !start && !stop)
        |=> (col_valid && col_out[COL_W-1:MAX_LOG] == $past(col_out[COL_W-1:MAX_LOG])));

    assert_cont_no_last_R6: assert property (@(posedge clk) disable iff (rst)
        (cont_live && col_valid) |-> !col_last);

endmodule

bind burst_col_seq burst_col_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_col (start_col),
    .len_sel   (len_sel),
    .intlv     (intlv),
    .stop      (stop),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last),
    .cfg_err   (cfg_err)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_sel = '0;
    logic       intlv = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] col_out;
    logic       col_valid, col_last, cfg_err;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq dut (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_sel(len_sel), .intlv(intlv), .stop(stop),
        .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
        .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int exp_col(input int base, input int lg, input int typ, input int i);
        int l, blk, off;
        l   = 1 << lg;
        blk = base - (base % l);
        off = base % l;
        return typ ? blk + (off ^ i) : blk + ((off + i) % l);
    endfunction

    // drive a start on the coming negedge
    task automatic launch(input int col, input int lg, input bit typ);
        @(negedge clk);
        start     = 1'b1;
        start_col = 9'(col);
        len_sel   = 3'(lg);
        intlv     = typ;
    endtask

    // check one beat at the next negedge
    task automatic beat(input int expc, input bit expl, input string req);
        @(negedge clk);
        start = 1'b0;
        chk(col_valid == 1'b1, {req, " valid"}, int'(col_valid), 1);
        chk(int'(col_out) == expc, {req, " col"}, int'(col_out), expc);
        chk(col_last == expl, {req, " last"}, int'(col_last), int'(expl));
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        start = 1'b0;
        stop  = 1'b0;
        chk(col_valid == 1'b0, {req, " idle"}, int'(col_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(col_valid == 0 && col_last == 0 && cfg_err == 0, "R1 flags", int'(col_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(col_valid == 0 && col_out == 0, "R1 after release", int'(col_out), 0);

        // R2 R3 R4 R5 R10: sweep of lengths, types and start offsets
        for (int lg = 0; lg < 4; lg++) begin
            for (int typ = 0; typ < 2; typ++) begin
                for (int off = 0; off < 8; off++) begin
                    int base = ((lg * 2 + typ) * 8 + 5) * 8 + off;
                    launch(base, lg, typ[0]);
                    for (int i = 0; i < (1 << lg); i++)
                        beat(exp_col(base, lg, typ, i), i == (1 << lg) - 1,
                             typ ? "R4 R5 interleaved" : "R3 R5 sequential");
                    idle("R2 length");
                end
            end
        end

        // R4 example 5 in length 8: 5,4,7,6,1,0,3,2
        launch(5, 3, 1'b1);
        beat(5, 0, "R4"); beat(4, 0, "R4"); beat(7, 0, "R4"); beat(6, 0, "R4");
        beat(1, 0, "R4"); beat(0, 0, "R4"); beat(3, 0, "R4"); beat(2, 1, "R4");
        idle("R4");

        // R6: continuous wrap 510 -> 0, stopped by R7
        launch(510, 4, 1'b0);
        beat(510, 0, "R6"); beat(511, 0, "R6"); beat(0, 0, "R6");
        beat(1, 0, "R6");
        stop = 1'b1;
        idle("R7 stop continuous");
        idle("R7 stays idle");

        // R7: stop during fixed burst
        launch(16, 3, 1'b0);
        beat(16, 0, "R7"); beat(17, 0, "R7");
        stop = 1'b1;
        idle("R7 stop fixed");

        // R7: start and stop together, start taken
        launch(64, 3, 1'b0);
        beat(64, 0, "R7");
        start = 1'b1; stop = 1'b1; start_col = 9'd101; len_sel = 3'd2; intlv = 1'b0;
        beat(101, 0, "R7 start wins");
        stop = 1'b0;
        beat(102, 0, "R7"); beat(103, 0, "R7"); beat(100, 1, "R7");
        idle("R7");

        // R8: continuous + interleaved rejected, aborts running burst
        launch(200, 3, 1'b0);
        beat(200, 0, "R8");
        start = 1'b1; len_sel = 3'd4; intlv = 1'b1; start_col = 9'd7;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1, "R8 err flag", int'(cfg_err), 1);
        chk(col_valid == 1'b0, "R8 no column", int'(col_valid), 0);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8 one cycle", int'(cfg_err), 0);
        chk(col_valid == 1'b0, "R8 burst aborted", int'(col_valid), 0);

        // R8: reserved length code
        launch(12, 6, 1'b0);
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1 && col_valid == 1'b0, "R8 reserved code", int'(cfg_err), 1);
        idle("R8 reserved");

        // R9: truncation mid-burst, then back-to-back on last beat
        launch(8, 3, 1'b0);
        beat(8, 0, "R9"); beat(9, 0, "R9"); beat(10, 0, "R9");
        start = 1'b1; start_col = 9'd33; len_sel = 3'd1; intlv = 1'b0;
        beat(33, 0, "R9 truncate");
        beat(32, 1, "R9 truncate");
        start = 1'b1; start_col = 9'd40; len_sel = 3'd1; intlv = 1'b0;
        beat(40, 0, "R9 back-to-back");
        beat(41, 1, "R9 back-to-back");
        idle("R9");

        // R2: single-beat bursts back to back
        launch(77, 0, 1'b0);
        beat(77, 1, "R2 single");
        start = 1'b1; start_col = 9'd78; len_sel = 3'd0;
        beat(78, 1, "R2 single b2b");
        idle("R2 single");

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule